// File: doc/BRIEF.md
# Compare-Value Timer with Register Frame

This block is a per-core event timer that watches a free-running 64-bit system count supplied from outside. It contains a physical timer and, when the `HAS_VIRT` parameter is set, a virtual timer. The virtual timer works from a virtual count, which is the physical count minus a programmable 64-bit offset. Each timer holds one trigger point, and software can program it in two ways. The first is an absolute 64-bit compare value. The second is a signed 32-bit countdown measured from the timer's present count.

Each timer has a control word with an enable bit, a mask bit and a read-only status bit. The timer drives a level interrupt while it is enabled and unmasked and its count is at or beyond the compare value. The interrupt is recomputed continuously from the stored state and the incoming count. Any control, compare or offset write therefore takes effect on the cycle after the write is accepted.

Software reaches every register through a simple request/response port. The port takes 4-byte and 8-byte little-endian accesses, and each access is answered exactly one cycle later.

Top module: `cvt_frame`

Register map (byte offsets). Every 64-bit register can also be reached as two 4-byte halves at offset +0 (low word) and +4 (high word).

| Offset | Register |
|--------|----------|
| 0x00 | physical count (read-only) |
| 0x08 | virtual count (read-only) |
| 0x10 | virtual offset |
| 0x20 | physical compare |
| 0x28 | physical control |
| 0x2C | physical countdown |
| 0x30 | virtual compare |
| 0x38 | virtual control |
| 0x3C | virtual countdown |

Control word layout: bit 0 is enable, bit 1 is mask, bit 2 is status.

## Requirements
- R1: The status bit (control bit 2) reads 1 exactly when the timer's count is greater than or equal to its 64-bit compare value. The mask bit does not affect it.
- R2: The interrupt output is high while enable (control bit 0) is 1, mask (control bit 1) is 0 and the status condition holds. It stays high as a level for as long as all three hold.
- R3: A control write takes effect at once. If the timer becomes enabled and unmasked while the condition already holds, the interrupt is high in the cycle after the write is accepted.
- R4: A 4-byte write to a countdown register (0x2C physical, 0x3C virtual) sets the compare value to the timer's count in the request cycle plus the written 32-bit value, sign-extended.
- R5: A read of a countdown register returns the low 32 bits of (compare value minus the timer's count in the request cycle).
- R6: The virtual count (0x08) equals the physical count minus the offset (0x10). The virtual timer compares against this virtual count, so a write to the offset re-evaluates its condition.
- R7: The request size code is 2 for a 4-byte access and 3 for an 8-byte access. A 4-byte access at offset +0 or +4 of a 64-bit register reaches its low or high word, and the data sits in bits 31:0.
- R8: The count registers (0x00 and 0x08) are read-only. Writes to them leave them unchanged.
- R9: Reads of unmapped locations return zero, and writes to them change nothing. Unmapped locations include 0x18, anything at 0x40 or above, 8-byte accesses to 0x28 or 0x38, and 4-byte accesses not aligned to 4 bytes.
- R10: An access with size code 0 or 1 is answered with the error flag set and read data zero, and it changes no state.
- R11: After reset both control words have enable and mask clear, and the compare values and the offset are zero. Both interrupts are therefore low.
- R12: Writes to the status bit are ignored. The status bit always reflects the compare condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count_i | input | 64 | Free-running physical system count |
| req_valid_i | input | 1 | Register access request in this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size code (2 = 4 bytes, 3 = 8 bytes) |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | 64 | Write data, little-endian; 4-byte writes use bits 31:0 |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Access had an illegal size |
| rsp_rdata_o | output | 64 | Read data; zero for writes, errors and unmapped reads |
| irq_phys_o | output | 1 | Physical timer level interrupt |
| irq_virt_o | output | 1 | Virtual timer level interrupt |

## Verification
The bench builds the block with `ADDR_W = 8` and `HAS_VIRT = 1`. The 8-bit address makes the window above 0x3F reachable, so reads and writes there can be checked as unmapped. Enabling the virtual timer puts the offset, the virtual count and the second timer instance within reach. With both in place, the bench can check that an offset write alone moves the virtual interrupt while the physical timer stays untouched. The bench drives the system count directly, which gives exact request-cycle values for the countdown reads and writes, including negative countdowns.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

   localparam int CNT_W = 64;
   localparam int HALF_W = CNT_W / 2;

   // access size codes
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_DWORD = 2'd3;

   // control word bit positions
   localparam int CTL_EN_BIT = 0;
   localparam int CTL_MASK_BIT = 1;
   localparam int CTL_STAT_BIT = 2;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_PCNT,
      SEL_VCNT,
      SEL_VOFF,
      SEL_PCMP,
      SEL_PCTL,
      SEL_PCD,
      SEL_VCMP,
      SEL_VCTL,
      SEL_VCD
   } reg_sel_e;

endpackage

// File: rtl/cvt_decode.sv
module cvt_decode
   import cvt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter bit HAS_VIRT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output logic              size_ok_o,
   output reg_sel_e          sel_o,
   output logic [1:0]        hmask_o
);

   localparam int WIN_LSB = 6;

   logic       in_win;
   logic       wide;
   logic       half;
   logic [2:0] slot;

   generate
      if (ADDR_W > WIN_LSB) begin : g_win
         assign in_win = ~|addr_i[ADDR_W-1:WIN_LSB];
      end else begin : g_nowin
         assign in_win = 1'b1;
      end
   endgenerate

   assign size_ok_o = (size_i == SZ_WORD) || (size_i == SZ_DWORD);
   assign wide = (size_i == SZ_DWORD);
   assign half = addr_i[2];
   assign slot = addr_i[5:3];
   assign hmask_o = wide ? 2'b11 : (half ? 2'b10 : 2'b01);

   always_comb begin
      sel_o = SEL_NONE;
      if (size_ok_o && in_win && (addr_i[1:0] == 2'b00) && !(wide && half)) begin
         unique case (slot)
            3'd0: sel_o = SEL_PCNT;
            3'd1: sel_o = HAS_VIRT ? SEL_VCNT : SEL_NONE;
            3'd2: sel_o = HAS_VIRT ? SEL_VOFF : SEL_NONE;
            3'd4: sel_o = SEL_PCMP;
            3'd5: sel_o = wide ? SEL_NONE : (half ? SEL_PCD : SEL_PCTL);
            3'd6: sel_o = HAS_VIRT ? SEL_VCMP : SEL_NONE;
            3'd7: sel_o = (!HAS_VIRT || wide) ? SEL_NONE : (half ? SEL_VCD : SEL_VCTL);
            default: sel_o = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/cvt_timer_unit.sv
module cvt_timer_unit
   import cvt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              wr_cmp_i,
   input  logic              wr_ctl_i,
   input  logic              wr_cd_i,
   input  logic [1:0]        hmask_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [HALF_W-1:0] ctl_rd_o,
   output logic [HALF_W-1:0] cd_rd_o,
   output logic              irq_o
);

   logic [CNT_W-1:0] cmp_q;
   logic             en_q;
   logic             mask_q;
   logic             cond;
   logic [CNT_W-1:0] cd_sext;
   logic [CNT_W-1:0] cd_diff;

   assign cond = (count_i >= cmp_q);
   assign cd_sext = {{HALF_W{wdata_i[HALF_W-1]}}, wdata_i[HALF_W-1:0]};
   assign cd_diff = cmp_q - count_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         en_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (wr_cmp_i) begin
            if (hmask_i == 2'b11) begin
               cmp_q <= wdata_i;
            end else if (hmask_i[1]) begin
               cmp_q[CNT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
            end else begin
               cmp_q[HALF_W-1:0] <= wdata_i[HALF_W-1:0];
            end
         end else if (wr_cd_i) begin
            cmp_q <= count_i + cd_sext;
         end
         if (wr_ctl_i) begin
            en_q <= wdata_i[CTL_EN_BIT];
            mask_q <= wdata_i[CTL_MASK_BIT];
         end
      end
   end

   always_comb begin
      ctl_rd_o = '0;
      ctl_rd_o[CTL_EN_BIT] = en_q;
      ctl_rd_o[CTL_MASK_BIT] = mask_q;
      ctl_rd_o[CTL_STAT_BIT] = cond;
   end

   assign cd_rd_o = cd_diff[HALF_W-1:0];
   assign cmp_o = cmp_q;
   assign irq_o = en_q && !mask_q && cond;

   // R4: countdown write lands as count plus sign-extended value
   a_r4_cd_sets_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cd_i && !wr_cmp_i |=> cmp_o == $past(count_i + cd_sext));

   // R3: enabling while the condition holds raises the interrupt next cycle
   a_r3_ctl_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl_i && wdata_i[CTL_EN_BIT] && !wdata_i[CTL_MASK_BIT] && !wr_cmp_i && !wr_cd_i
      && (count_i >= cmp_o)
      |=> irq_o || (count_i < $past(count_i)));

   // R2: the interrupt is a level that holds while nothing is written
   a_r2_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !wr_ctl_i && !wr_cmp_i && !wr_cd_i
      |=> irq_o || (count_i < $past(count_i)));

   // R12: a control write never sets the status bit on its own
   a_r12_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl_i && !wr_cmp_i && !wr_cd_i && (count_i < cmp_o)
      |=> !ctl_rd_o[CTL_STAT_BIT] || (count_i > $past(count_i)));

endmodule

// File: rtl/cvt_frame.sv
module cvt_frame
   import cvt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter bit HAS_VIRT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       sys_count_i,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [1:0]        req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [63:0]       req_wdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_err_o,
   output logic [63:0]       rsp_rdata_o,
   output logic              irq_phys_o,
   output logic              irq_virt_o
);

   generate
      if (ADDR_W < 6) begin : g_chk_addr
         $error("cvt_frame: ADDR_W must cover the 64-byte frame");
      end
   endgenerate

   logic             size_ok;
   reg_sel_e         sel;
   logic [1:0]       hmask;
   logic             wr_go;
   logic             rd_go;
   logic [CNT_W-1:0] voff_q;
   logic [CNT_W-1:0] vcount;
   logic [CNT_W-1:0] p_cmp;
   logic [CNT_W-1:0] v_cmp;
   logic [HALF_W-1:0] p_ctl;
   logic [HALF_W-1:0] p_cd;
   logic [HALF_W-1:0] v_ctl;
   logic [HALF_W-1:0] v_cd;
   logic [CNT_W-1:0] rd_full;
   logic [CNT_W-1:0] rd_lane;

   cvt_decode #(.ADDR_W(ADDR_W), .HAS_VIRT(HAS_VIRT)) u_dec (
      .addr_i   (req_addr_i),
      .size_i   (req_size_i),
      .size_ok_o(size_ok),
      .sel_o    (sel),
      .hmask_o  (hmask)
   );

   assign wr_go = req_valid_i && req_write_i && size_ok;
   assign rd_go = req_valid_i && !req_write_i && size_ok;

   cvt_timer_unit u_phys (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (sys_count_i),
      .wr_cmp_i(wr_go && (sel == SEL_PCMP)),
      .wr_ctl_i(wr_go && (sel == SEL_PCTL)),
      .wr_cd_i (wr_go && (sel == SEL_PCD)),
      .hmask_i (hmask),
      .wdata_i (req_wdata_i),
      .cmp_o   (p_cmp),
      .ctl_rd_o(p_ctl),
      .cd_rd_o (p_cd),
      .irq_o   (irq_phys_o)
   );

   generate
      if (HAS_VIRT) begin : g_virt
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               voff_q <= '0;
            end else if (wr_go && (sel == SEL_VOFF)) begin
               if (hmask == 2'b11) begin
                  voff_q <= req_wdata_i;
               end else if (hmask[1]) begin
                  voff_q[CNT_W-1:HALF_W] <= req_wdata_i[HALF_W-1:0];
               end else begin
                  voff_q[HALF_W-1:0] <= req_wdata_i[HALF_W-1:0];
               end
            end
         end

         assign vcount = sys_count_i - voff_q;

         cvt_timer_unit u_virt (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_i (vcount),
            .wr_cmp_i(wr_go && (sel == SEL_VCMP)),
            .wr_ctl_i(wr_go && (sel == SEL_VCTL)),
            .wr_cd_i (wr_go && (sel == SEL_VCD)),
            .hmask_i (hmask),
            .wdata_i (req_wdata_i),
            .cmp_o   (v_cmp),
            .ctl_rd_o(v_ctl),
            .cd_rd_o (v_cd),
            .irq_o   (irq_virt_o)
         );
      end else begin : g_novirt
         assign voff_q = '0;
         assign vcount = '0;
         assign v_cmp = '0;
         assign v_ctl = '0;
         assign v_cd = '0;
         assign irq_virt_o = 1'b0;
      end
   endgenerate

   // 32-bit registers sit in the byte lane matching their address
   always_comb begin
      unique case (sel)
         SEL_PCNT: rd_full = sys_count_i;
         SEL_VCNT: rd_full = vcount;
         SEL_VOFF: rd_full = voff_q;
         SEL_PCMP: rd_full = p_cmp;
         SEL_PCTL: rd_full = {{HALF_W{1'b0}}, p_ctl};
         SEL_PCD:  rd_full = {p_cd, {HALF_W{1'b0}}};
         SEL_VCMP: rd_full = v_cmp;
         SEL_VCTL: rd_full = {{HALF_W{1'b0}}, v_ctl};
         SEL_VCD:  rd_full = {v_cd, {HALF_W{1'b0}}};
         default:  rd_full = '0;
      endcase
   end

   always_comb begin
      unique case (hmask)
         2'b10:   rd_lane = {{HALF_W{1'b0}}, rd_full[CNT_W-1:HALF_W]};
         2'b01:   rd_lane = {{HALF_W{1'b0}}, rd_full[HALF_W-1:0]};
         default: rd_lane = rd_full;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_err_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         rsp_err_o <= req_valid_i && !size_ok;
         rsp_rdata_o <= rd_go ? rd_lane : '0;
      end
   end

   // R10: an errored access leaves the offset untouched
   a_r10_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> voff_q == $past(voff_q));

   // R9: unmapped reads answer zero
   a_r9_unmapped_raz: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && !req_write_i && (sel == SEL_NONE) |=> rsp_rdata_o == '0);

   // R8: a full count read returns the count of the request cycle
   a_r8_count_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && (sel == SEL_PCNT) && (hmask == 2'b11) |=> rsp_rdata_o == $past(sys_count_i));

   // R7: every request is answered exactly one cycle later
   a_r7_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);

endmodule

// File: tb/cvt_frame_tb.sv
module cvt_frame_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [63:0]       sys_count = '0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [1:0]        req_size = 2'd2;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [63:0]       req_wdata = '0;
   logic              rsp_valid;
   logic              rsp_err;
   logic [63:0]       rsp_rdata;
   logic              irq_phys;
   logic              irq_virt;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [63:0] q_data[$];
   logic        q_err[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cvt_frame #(.ADDR_W(ADDR_W), .HAS_VIRT(1'b1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sys_count_i(sys_count),
      .req_valid_i(req_valid),
      .req_write_i(req_write),
      .req_size_i (req_size),
      .req_addr_i (req_addr),
      .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid),
      .rsp_err_o  (rsp_err),
      .rsp_rdata_o(rsp_rdata),
      .irq_phys_o (irq_phys),
      .irq_virt_o (irq_virt)
   );

   // monitor: pop expected responses and compare
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_checks++;
         if (q_data.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected response: actual data %h expected none", rsp_rdata);
         end else begin
            logic [63:0] ed;
            logic        ee;
            string       et;
            ed = q_data.pop_front();
            ee = q_err.pop_front();
            et = q_tag.pop_front();
            if (rsp_rdata !== ed || rsp_err !== ee) begin
               n_fail++;
               $display("FAIL %s: actual data %h err %b, expected data %h err %b",
                        et, rsp_rdata, rsp_err, ed, ee);
            end
         end
      end
   end

   task automatic acc(input logic wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                      input logic [63:0] wd, input logic [63:0] exp_d, input logic exp_e,
                      input string tag);
      @(negedge clk);
      q_data.push_back(exp_d);
      q_err.push_back(exp_e);
      q_tag.push_back(tag);
      req_valid = 1'b1;
      req_write = wr;
      req_size = sz;
      req_addr = a;
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic rd4(input logic [ADDR_W-1:0] a, input logic [63:0] e, input string tag);
      acc(1'b0, 2'd2, a, '0, e, 1'b0, tag);
   endtask

   task automatic rd8(input logic [ADDR_W-1:0] a, input logic [63:0] e, input string tag);
      acc(1'b0, 2'd3, a, '0, e, 1'b0, tag);
   endtask

   task automatic wr4(input logic [ADDR_W-1:0] a, input logic [63:0] d, input string tag);
      acc(1'b1, 2'd2, a, d, '0, 1'b0, tag);
   endtask

   task automatic wr8(input logic [ADDR_W-1:0] a, input logic [63:0] d, input string tag);
      acc(1'b1, 2'd3, a, d, '0, 1'b0, tag);
   endtask

   task automatic set_cnt(input logic [63:0] v);
      @(negedge clk);
      sys_count = v;
   endtask

   task automatic chk_irq(input logic ep, input logic ev, input string tag);
      n_checks++;
      if (irq_phys !== ep || irq_virt !== ev) begin
         n_fail++;
         $display("FAIL %s: actual irq phys %b virt %b, expected phys %b virt %b",
                  tag, irq_phys, irq_virt, ep, ev);
      end
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (q_data.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL missing responses: actual %0d pending expected 0", q_data.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      finished = 1'b1;
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk_irq(1'b0, 1'b0, "R11 irq after reset");
      rd4(8'h28, 64'h4, "R11 phys control at reset (status set, 0>=0)");
      rd8(8'h20, 64'h0, "R11 phys compare at reset");
      rd8(8'h10, 64'h0, "R11 offset at reset");
      rd4(8'h38, 64'h4, "R11 virt control at reset");

      // R1 / R2 compare and interrupt
      set_cnt(64'd100);
      wr8(8'h20, 64'd200, "R7 write compare 8B");
      rd4(8'h28, 64'h0, "R1 status clear below compare");
      wr4(8'h28, 64'h1, "R2 enable");
      chk_irq(1'b0, 1'b0, "R2 enabled, below compare");
      set_cnt(64'd200);
      @(negedge clk);
      chk_irq(1'b1, 1'b0, "R2 count reached compare");
      rd4(8'h28, 64'h5, "R1 status set at compare");
      wr4(8'h28, 64'h3, "R2 mask");
      chk_irq(1'b0, 1'b0, "R2 masked");
      rd4(8'h28, 64'h7, "R1 status independent of mask");

      // R12 status write ignored
      set_cnt(64'd150);
      wr4(8'h28, 64'h5, "R12 write status bit");
      rd4(8'h28, 64'h1, "R12 status bit not written");

      // R3 immediate re-evaluation on control write
      set_cnt(64'd300);
      wr4(8'h28, 64'h0, "R3 disable");
      chk_irq(1'b0, 1'b0, "R3 disabled");
      wr4(8'h28, 64'h1, "R3 enable with condition met");
      chk_irq(1'b1, 1'b0, "R3 irq at once after enable");

      // R4 / R5 countdown view
      set_cnt(64'd1000);
      wr4(8'h2C, 64'hFFFF_FFF6, "R4 countdown write -10");
      chk_irq(1'b1, 1'b0, "R4 negative countdown fires");
      rd8(8'h20, 64'd990, "R4 compare after countdown write");
      rd4(8'h2C, 64'hFFFF_FFF6, "R5 countdown read -10");
      set_cnt(64'd1005);
      rd4(8'h2C, 64'hFFFF_FFF1, "R5 countdown read -15");
      wr4(8'h2C, 64'd50, "R4 countdown write +50");
      chk_irq(1'b0, 1'b0, "R4 positive countdown pending");
      rd4(8'h20, 64'd1055, "R7 compare low half");
      rd4(8'h24, 64'd0, "R7 compare high half");

      // R7 half write
      wr4(8'h24, 64'd1, "R7 write compare high half");
      rd8(8'h20, 64'h1_0000_041F, "R7 compare after half write");

      // R8 read-only count
      set_cnt(64'h1234_5678_9ABC_DEF0);
      rd8(8'h00, 64'h1234_5678_9ABC_DEF0, "R8 count read");
      wr8(8'h00, 64'h0, "R8 write to count");
      rd8(8'h00, 64'h1234_5678_9ABC_DEF0, "R8 count unchanged");
      rd4(8'h04, 64'h1234_5678, "R7 count high half");

      // R6 virtual count and offset
      set_cnt(64'd1000);
      wr8(8'h10, 64'd100, "R6 offset write");
      rd8(8'h08, 64'd900, "R6 virtual count");
      wr8(8'h30, 64'd950, "R6 virtual compare");
      wr4(8'h38, 64'h1, "R6 virtual enable");
      chk_irq(1'b0, 1'b0, "R6 virtual below compare");
      wr4(8'h10, 64'd40, "R6 offset low half write");
      chk_irq(1'b0, 1'b1, "R6 offset change fires virtual");
      rd4(8'h3C, 64'hFFFF_FFF6, "R5 virtual countdown read");
      rd4(8'h38, 64'h5, "R6 virtual control");

      // R9 unmapped
      rd8(8'h18, 64'h0, "R9 unmapped 0x18");
      rd4(8'h40, 64'h0, "R9 unmapped 0x40");
      rd8(8'h28, 64'h0, "R9 8B on control");
      wr8(8'h28, 64'h0, "R9 8B write on control");
      rd4(8'h28, 64'h1, "R9 control unchanged");
      rd4(8'h29, 64'h0, "R9 misaligned read");
      wr8(8'h18, 64'hFFFF, "R9 unmapped write");
      rd8(8'h10, 64'd40, "R9 offset unchanged");

      // R10 illegal sizes
      acc(1'b1, 2'd0, 8'h10, 64'd7, 64'h0, 1'b1, "R10 write size 0");
      rd8(8'h10, 64'd40, "R10 offset unchanged");
      acc(1'b0, 2'd1, 8'h00, 64'h0, 64'h0, 1'b1, "R10 read size 1");
      acc(1'b1, 2'd1, 8'h38, 64'h0, 64'h0, 1'b1, "R10 write size 1 to control");
      chk_irq(1'b0, 1'b1, "R10 virtual still enabled");

      finish_run();
   end

endmodule